// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit sits between instruction decode and the load/store datapath. For each instruction it is given a 4-bit addressing-mode code, the displacement field from the end of the instruction word, the current program counter, and the values already read for a base register, an index register and a pointer register. From these it forms one result. The result is an immediate operand, a register operand selector, a data memory address, or a branch target for the next instruction fetch.

In the two-step indirect mode the unit reads a pointer word through a request/response memory port. The word returned by that read becomes the address. In the four pointer-update modes the unit also produces a one-cycle write-back request that carries the pointer register number and the stepped pointer value. It takes the step before forming the address in the pre-update modes and after it in the post-update modes.

Instructions arrive through a valid/ready handshake, and results leave through a second one. The unit holds one instruction at a time. The displacement is sign-extended to 32 bits before any addition, and all sums wrap modulo 2^32.

Top module: `eag_unit`

## Requirements
- R1: Mode 0 (immediate) returns kind 0 with the sign-extended displacement as the value, and issues no memory request.
- R2: Mode 1 (direct) returns kind 2 (memory address) with the sign-extended displacement as the address.
- R3: Mode 2 (register) returns kind 1, with the register number zero-extended as the value. No address is formed.
- R4: Mode 3 (two-step indirect) first presents a memory request at the sign-extended displacement address. That request stays valid and stable until the memory accepts it. The output becomes valid only after a response is received, and it carries kind 2 with the response word as the address.
- R5: Mode 4 (register pointer) returns kind 2 with the pointer register value as the address.
- R6: Mode 5 (program-relative) returns kind 3 (next-instruction target), with the value PC plus the sign-extended displacement, modulo 2^32.
- R7: Mode 6 returns the base register plus the sign-extended displacement, and mode 7 returns the index register plus the sign-extended displacement, both as kind 2 and both modulo 2^32.
- R8: Modes 8 (post-increment) and 9 (post-decrement) return kind 2 with the unmodified pointer as the address. They write back the pointer plus STEP or minus STEP.
- R9: Modes 10 (pre-increment) and 11 (pre-decrement) write back the pointer plus STEP or minus STEP, and return that same stepped value as the kind-2 address.
- R10: The write-back request is valid for exactly one cycle, in the cycle right after the instruction is accepted. It occurs only for modes 8 to 11 and carries the pointer register number.
- R11: Mode codes 12 to 15 return the illegal flag with kind 0 and value 0. They produce no memory request and no write-back.
- R12: in_ready is low while an instruction is in progress. While out_valid is high and out_ready is low, every output field holds steady.
- R13: During reset, and for two cycles after rst_n rises, in_ready, out_valid, mem_req_valid and wb_valid are low. After that, in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction fields are valid |
| in_ready | output | 1 | Unit can accept an instruction |
| in_mode | input | 4 | Addressing-mode code |
| in_disp | input | DISP_W | Displacement field |
| in_pc | input | 32 | Current program counter |
| in_base | input | 32 | Base register value |
| in_index | input | 32 | Index register value |
| in_ptr | input | 32 | Pointer register value |
| in_reg_id | input | REG_W | Register number (operand selector or pointer register) |
| mem_req_valid | output | 1 | Pointer-read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Pointer-read address |
| mem_rsp_valid | input | 1 | Pointer-read data valid |
| mem_rsp_data | input | 32 | Pointer word read from memory |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_kind | output | 2 | 0 immediate, 1 register, 2 memory address, 3 branch target |
| out_value | output | 32 | Operand, register number or address |
| out_illegal | output | 1 | Mode code not defined |
| wb_valid | output | 1 | Pointer write-back pulse |
| wb_reg | output | REG_W | Register to write back |
| wb_data | output | 32 | New pointer value |

## Verification
The bench builds the unit with a 12-bit displacement and STEP set to 8, not the defaults of 16 and 4. The 12-bit displacement moves the sign bit away from a byte boundary, so an extension that is hard-wired to 16 bits is exposed. The step of 8 separates a correct step from a constant 4 or 1. With 12-bit displacements, the directed values reach the most negative offset, and wrap-around occurs in the PC, pointer and base sums. The test drives backpressure on the output and on the memory request, and varies the memory response latency. Under these conditions it confirms that results hold steady and that the indirect result waits for the response.

// File: rtl/eag_pkg.sv
package eag_pkg;

  localparam int ADDR_W = 32;
  localparam int MODE_W = 4;

  // Mode codes
  localparam logic [MODE_W-1:0] MD_IMM     = 4'd0;
  localparam logic [MODE_W-1:0] MD_DIRECT  = 4'd1;
  localparam logic [MODE_W-1:0] MD_REG     = 4'd2;
  localparam logic [MODE_W-1:0] MD_INDIR   = 4'd3;
  localparam logic [MODE_W-1:0] MD_PTR     = 4'd4;
  localparam logic [MODE_W-1:0] MD_PCREL   = 4'd5;
  localparam logic [MODE_W-1:0] MD_BASE    = 4'd6;
  localparam logic [MODE_W-1:0] MD_INDEX   = 4'd7;
  localparam logic [MODE_W-1:0] MD_POSTINC = 4'd8;
  localparam logic [MODE_W-1:0] MD_POSTDEC = 4'd9;
  localparam logic [MODE_W-1:0] MD_PREINC  = 4'd10;
  localparam logic [MODE_W-1:0] MD_PREDEC  = 4'd11;

  typedef enum logic [1:0] {
    KD_IMM  = 2'd0,
    KD_REG  = 2'd1,
    KD_MEM  = 2'd2,
    KD_JUMP = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MREQ  = 2'd1,
    ST_MWAIT = 2'd2,
    ST_HOLD  = 2'd3
  } state_e;

  typedef struct packed {
    kind_e             kind;
    logic [ADDR_W-1:0] value;
    logic              illegal;
    logic              need_mem;
    logic              wb_en;
    logic [ADDR_W-1:0] wb_data;
  } calc_t;

endpackage

// File: rtl/eag_rst_sync.sv
module eag_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/eag_addr_calc.sv
module eag_addr_calc
  import eag_pkg::*;
#(
  parameter int DISP_W = 16,
  parameter int REG_W  = 6,
  parameter int STEP   = 4
) (
  input  logic [MODE_W-1:0] mode,
  input  logic [DISP_W-1:0] disp,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] index,
  input  logic [ADDR_W-1:0] ptr,
  input  logic [REG_W-1:0]  reg_id,
  output calc_t             res
);

  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

  logic [ADDR_W-1:0] disp_x;
  logic [ADDR_W-1:0] ptr_up;
  logic [ADDR_W-1:0] ptr_dn;
  logic [ADDR_W-1:0] reg_x;

  // Sign extension variant chosen by the displacement width
  generate
    if (DISP_W >= ADDR_W) begin : g_wide
      assign disp_x = disp[ADDR_W-1:0];
    end else begin : g_ext
      assign disp_x = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
    end
  endgenerate

  assign ptr_up = ptr + STEP_V;
  assign ptr_dn = ptr - STEP_V;
  assign reg_x  = ADDR_W'(reg_id);

  always_comb begin
    res          = '0;
    res.kind     = KD_MEM;
    unique case (mode)
      MD_IMM: begin
        res.kind  = KD_IMM;
        res.value = disp_x;
      end
      MD_DIRECT: begin
        res.value = disp_x;
      end
      MD_REG: begin
        res.kind  = KD_REG;
        res.value = reg_x;
      end
      MD_INDIR: begin
        res.value    = disp_x;
        res.need_mem = 1'b1;
      end
      MD_PTR: begin
        res.value = ptr;
      end
      MD_PCREL: begin
        res.kind  = KD_JUMP;
        res.value = pc + disp_x;
      end
      MD_BASE: begin
        res.value = base + disp_x;
      end
      MD_INDEX: begin
        res.value = index + disp_x;
      end
      MD_POSTINC: begin
        res.value   = ptr;
        res.wb_en   = 1'b1;
        res.wb_data = ptr_up;
      end
      MD_POSTDEC: begin
        res.value   = ptr;
        res.wb_en   = 1'b1;
        res.wb_data = ptr_dn;
      end
      MD_PREINC: begin
        res.value   = ptr_up;
        res.wb_en   = 1'b1;
        res.wb_data = ptr_up;
      end
      MD_PREDEC: begin
        res.value   = ptr_dn;
        res.wb_en   = 1'b1;
        res.wb_data = ptr_dn;
      end
      default: begin
        res.kind    = KD_IMM;
        res.illegal = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/eag_seq.sv
module eag_seq
  import eag_pkg::*;
#(
  parameter int REG_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  calc_t             res,
  input  logic [REG_W-1:0]  reg_id,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_kind,
  output logic [ADDR_W-1:0] out_value,
  output logic              out_illegal,
  output logic              wb_valid,
  output logic [REG_W-1:0]  wb_reg,
  output logic [ADDR_W-1:0] wb_data
);

  state_e            state_q, state_d;
  kind_e             kind_q;
  logic              illegal_q;
  logic [ADDR_W-1:0] value_q, value_d;
  logic              wb_valid_q, wb_valid_d;
  logic [REG_W-1:0]  wb_reg_q;
  logic [ADDR_W-1:0] wb_data_q;

  logic accept;
  logic ld_res;
  logic ld_rsp;
  logic ld_value;
  logic ld_wb;

  assign in_ready = rst_n && (state_q == ST_IDLE);
  assign accept   = in_valid && in_ready;

  // Next-state and enables
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept)        state_d = res.need_mem ? ST_MREQ : ST_HOLD;
      ST_MREQ:  if (mem_req_ready) state_d = ST_MWAIT;
      ST_MWAIT: if (mem_rsp_valid) state_d = ST_HOLD;
      ST_HOLD:  if (out_ready)     state_d = ST_IDLE;
      default:                     state_d = ST_IDLE;
    endcase
  end

  assign ld_res     = accept;
  assign ld_rsp     = (state_q == ST_MWAIT) && mem_rsp_valid;
  assign ld_value   = ld_res || ld_rsp;
  assign value_d    = ld_rsp ? mem_rsp_data : res.value;
  assign ld_wb      = accept && res.wb_en;
  assign wb_valid_d = ld_wb;

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      wb_valid_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      wb_valid_q <= wb_valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q    <= KD_IMM;
      illegal_q <= 1'b0;
    end else if (ld_res) begin
      kind_q    <= res.kind;
      illegal_q <= res.illegal;
    end
  end

  // The indirect request address shares the value register with the result
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value_q <= '0;
    end else if (ld_value) begin
      value_q <= value_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_reg_q  <= '0;
      wb_data_q <= '0;
    end else if (ld_wb) begin
      wb_reg_q  <= reg_id;
      wb_data_q <= res.wb_data;
    end
  end

  assign mem_req_valid = (state_q == ST_MREQ);
  assign mem_req_addr  = value_q;
  assign out_valid     = (state_q == ST_HOLD);
  assign out_kind      = kind_q;
  assign out_value     = value_q;
  assign out_illegal   = illegal_q;
  assign wb_valid      = wb_valid_q;
  assign wb_reg        = wb_reg_q;
  assign wb_data       = wb_data_q;

endmodule

// File: rtl/eag_unit.sv
module eag_unit
  import eag_pkg::*;
#(
  parameter int DISP_W = 16,
  parameter int REG_W  = 6,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        in_mode,
  input  logic [DISP_W-1:0] in_disp,
  input  logic [31:0]       in_pc,
  input  logic [31:0]       in_base,
  input  logic [31:0]       in_index,
  input  logic [31:0]       in_ptr,
  input  logic [REG_W-1:0]  in_reg_id,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [31:0]       mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_kind,
  output logic [31:0]       out_value,
  output logic              out_illegal,
  output logic              wb_valid,
  output logic [REG_W-1:0]  wb_reg,
  output logic [31:0]       wb_data
);

  logic  rst_n_sync;
  calc_t calc_res;

  eag_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  eag_addr_calc #(
    .DISP_W (DISP_W),
    .REG_W  (REG_W),
    .STEP   (STEP)
  ) u_calc (
    .mode   (in_mode),
    .disp   (in_disp),
    .pc     (in_pc),
    .base   (in_base),
    .index  (in_index),
    .ptr    (in_ptr),
    .reg_id (in_reg_id),
    .res    (calc_res)
  );

  eag_seq #(
    .REG_W (REG_W)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n_sync),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .res           (calc_res),
    .reg_id        (in_reg_id),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_kind      (out_kind),
    .out_value     (out_value),
    .out_illegal   (out_illegal),
    .wb_valid      (wb_valid),
    .wb_reg        (wb_reg),
    .wb_data       (wb_data)
  );

endmodule

// File: rtl/eag_unit_chk.sv
module eag_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [3:0]  in_mode,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [31:0] mem_req_addr,
  input logic        out_valid,
  input logic        out_ready,
  input logic [1:0]  out_kind,
  input logic [31:0] out_value,
  input logic        out_illegal,
  input logic        wb_valid
);

  p_imm_nomem_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_mode == 4'd0) |=>
      (out_valid && out_kind == 2'd0 && !mem_req_valid));

  p_indir_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_mode == 4'd3) |=> (mem_req_valid && !out_valid));

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  p_req_out_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_valid, mem_req_valid}));

  p_wb_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> !wb_valid);

  p_illegal_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_mode >= 4'd12) |=>
      (out_valid && out_illegal && !mem_req_valid && !wb_valid));

  p_out_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_value) && $stable(out_kind) && $stable(out_illegal)));

  p_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

endmodule

bind eag_unit eag_unit_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .in_mode       (in_mode),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_kind      (out_kind),
  .out_value     (out_value),
  .out_illegal   (out_illegal),
  .wb_valid      (wb_valid)
);

// File: tb/eag_unit_tb.sv
module eag_unit_tb;

  localparam int DISP_W = 12;
  localparam int REG_W  = 6;
  localparam int STEP   = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid;
  logic              in_ready;
  logic [3:0]        in_mode;
  logic [DISP_W-1:0] in_disp;
  logic [31:0]       in_pc, in_base, in_index, in_ptr;
  logic [REG_W-1:0]  in_reg_id;
  logic              mem_req_valid, mem_req_ready;
  logic [31:0]       mem_req_addr;
  logic              mem_rsp_valid;
  logic [31:0]       mem_rsp_data;
  logic              out_valid, out_ready;
  logic [1:0]        out_kind;
  logic [31:0]       out_value;
  logic              out_illegal;
  logic              wb_valid;
  logic [REG_W-1:0]  wb_reg;
  logic [31:0]       wb_data;

  always #5 clk = ~clk;

  eag_unit #(.DISP_W(DISP_W), .REG_W(REG_W), .STEP(STEP)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_mode(in_mode), .in_disp(in_disp),
    .in_pc(in_pc), .in_base(in_base), .in_index(in_index), .in_ptr(in_ptr),
    .in_reg_id(in_reg_id),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
    .out_value(out_value), .out_illegal(out_illegal),
    .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_data(wb_data)
  );

  typedef struct {
    logic [1:0]  kind;
    logic [31:0] value;
    logic        illegal;
    string       tag;
  } exp_out_t;

  typedef struct {
    int               cyc;
    logic [REG_W-1:0] rid;
    logic [31:0]      data;
    string            tag;
  } exp_wb_t;

  exp_out_t    oq[$];
  exp_wb_t     wq[$];
  logic [31:0] mq[$];

  int compared   = 0;
  int mismatched = 0;
  int cyc        = 0;
  bit done       = 0;
  bit bp_en      = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] memf(logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h5A5A_C3C3;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Reference model: one instruction
  task automatic send(logic [3:0] m, logic [DISP_W-1:0] d, logic [31:0] pc,
                      logic [31:0] base, logic [31:0] idx, logic [31:0] ptr,
                      logic [REG_W-1:0] rid);
    exp_out_t e;
    exp_wb_t  w;
    bit       has_wb = 0;
    logic [31:0] dx = {{(32-DISP_W){d[DISP_W-1]}}, d};
    logic [31:0] up = ptr + 32'(STEP);
    logic [31:0] dn = ptr - 32'(STEP);
    e.illegal = 1'b0;
    e.kind    = 2'd2;
    w.data    = '0;
    case (m)
      4'd0:  begin e.kind = 2'd0; e.value = dx; e.tag = "R1"; end
      4'd1:  begin e.value = dx; e.tag = "R2"; end
      4'd2:  begin e.kind = 2'd1; e.value = 32'(rid); e.tag = "R3"; end
      4'd3:  begin e.value = memf(dx); e.tag = "R4"; mq.push_back(dx); end
      4'd4:  begin e.value = ptr; e.tag = "R5"; end
      4'd5:  begin e.kind = 2'd3; e.value = pc + dx; e.tag = "R6"; end
      4'd6:  begin e.value = base + dx; e.tag = "R7"; end
      4'd7:  begin e.value = idx + dx; e.tag = "R7"; end
      4'd8:  begin e.value = ptr; e.tag = "R8"; has_wb = 1; w.data = up; end
      4'd9:  begin e.value = ptr; e.tag = "R8"; has_wb = 1; w.data = dn; end
      4'd10: begin e.value = up; e.tag = "R9"; has_wb = 1; w.data = up; end
      4'd11: begin e.value = dn; e.tag = "R9"; has_wb = 1; w.data = dn; end
      default: begin e.kind = 2'd0; e.value = '0; e.illegal = 1'b1; e.tag = "R11"; end
    endcase
    @(negedge clk);
    in_valid = 1'b1; in_mode = m; in_disp = d; in_pc = pc; in_base = base;
    in_index = idx; in_ptr = ptr; in_reg_id = rid;
    while (!in_ready) @(negedge clk);
    oq.push_back(e);
    if (has_wb) begin
      w.cyc = cyc + 1; w.rid = rid; w.tag = "R10";
      wq.push_back(w);
    end
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  // Ready drivers, changed away from both edges
  always @(posedge clk) begin
    #2;
    out_ready     <= bp_en ? ((cyc % 3) != 1) : 1'b1;
    mem_req_ready <= bp_en ? ((cyc % 4) != 0) : 1'b1;
  end

  // Memory responder with varying latency
  initial begin
    int lat = 1;
    logic [31:0] addr;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      if (rst_n && mem_req_valid && mem_req_ready) begin
        addr = mem_req_addr;
        @(posedge clk);
        repeat (lat) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = memf(addr);
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        lat = (lat % 3) + 1;
      end
    end
  end

  // Per-cycle comparison against the model queues
  always @(negedge clk) begin
    exp_out_t e;
    exp_wb_t  w;
    if (rst_n && !done) begin
      if (out_valid) chk("R12", "in_ready while busy", 32'(in_ready), 32'd0);
      if (out_valid && out_ready) begin
        if (oq.size() == 0) chk("R11", "unexpected output", 32'd1, 32'd0);
        else begin
          e = oq.pop_front();
          chk(e.tag, "kind", 32'(out_kind), 32'(e.kind));
          chk(e.tag, "value", out_value, e.value);
          chk(e.tag, "illegal", 32'(out_illegal), 32'(e.illegal));
        end
      end
      if (wb_valid) begin
        if (wq.size() == 0) chk("R10", "unexpected write-back", 32'd1, 32'd0);
        else begin
          w = wq.pop_front();
          chk(w.tag, "wb cycle", 32'(cyc), 32'(w.cyc));
          chk(w.tag, "wb reg", 32'(wb_reg), 32'(w.rid));
          chk("R8", "wb data", wb_data, w.data);
        end
      end
      if (mem_req_valid && mq.size() == 0)
        chk("R11", "unexpected memory request", 32'd1, 32'd0);
      else if (mem_req_valid && mem_req_ready) begin
        chk("R4", "request address", mem_req_addr, mq.pop_front());
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      mismatched++;
      $display("FAIL R12 watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] r = 32'hACE1_2357;
    rst_n = 1'b0; in_valid = 1'b0; in_mode = '0; in_disp = '0; in_pc = '0;
    in_base = '0; in_index = '0; in_ptr = '0; in_reg_id = '0;
    out_ready = 1'b1; mem_req_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R13", "out_valid in reset", 32'(out_valid), 32'd0);
    chk("R13", "in_ready in reset", 32'(in_ready), 32'd0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R13", "in_ready while syncing", 32'(in_ready), 32'd0);
    repeat (3) @(negedge clk);
    chk("R13", "in_ready after reset", 32'(in_ready), 32'd1);
    chk("R13", "mem_req_valid after reset", 32'(mem_req_valid), 32'd0);
    chk("R13", "wb_valid after reset", 32'(wb_valid), 32'd0);

    send(4'd0, 12'h7FF, 0, 0, 0, 0, 0);
    send(4'd0, 12'h800, 0, 0, 0, 0, 0);
    send(4'd1, 12'hFF0, 0, 0, 0, 0, 0);
    send(4'd2, 12'h000, 0, 0, 0, 0, 6'd45);
    send(4'd3, 12'h123, 0, 0, 0, 0, 0);
    send(4'd3, 12'hF00, 0, 0, 0, 0, 0);
    send(4'd4, 12'h000, 0, 0, 0, 32'hDEAD_BEE0, 0);
    send(4'd5, 12'h010, 32'hFFFF_FFF8, 0, 0, 0, 0);
    send(4'd5, 12'hFFC, 32'h0000_1000, 0, 0, 0, 0);
    send(4'd6, 12'h800, 0, 32'h0000_4000, 0, 0, 0);
    send(4'd7, 12'h7F0, 0, 0, 32'h0000_0100, 0, 0);
    send(4'd8, 12'h000, 0, 0, 0, 32'hFFFF_FFFC, 6'd7);
    send(4'd9, 12'h000, 0, 0, 0, 32'h0000_0000, 6'd63);
    send(4'd10, 12'h000, 0, 0, 0, 32'h0000_2000, 6'd1);
    send(4'd11, 12'h000, 0, 0, 0, 32'h0000_0004, 6'd2);
    for (int m = 12; m < 16; m++) send(4'(m), 12'h5A5, 1, 2, 3, 4, 6'd9);

    bp_en = 1;
    for (int i = 0; i < 150; i++) begin
      logic [31:0] a, b;
      r = {r[30:0], r[31] ^ r[21] ^ r[1] ^ r[0]};
      a = r * 32'd2654435761;
      b = a ^ {r[15:0], r[31:16]};
      send(r[3:0], a[DISP_W-1:0], b, a + 32'h77, b ^ 32'h1234, {a[31:2], 2'b00}, r[REG_W+3:4]);
    end

    for (int k = 0; k < 200; k++) begin
      if (oq.size() == 0 && wq.size() == 0 && mq.size() == 0) break;
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
    chk("R12", "outputs left undelivered", 32'(oq.size()), 32'd0);
    chk("R10", "write-backs left undelivered", 32'(wq.size()), 32'd0);
    chk("R4", "requests left unissued", 32'(mq.size()), 32'd0);
    done = 1;
    summary();
    $finish;
  end

endmodule